// File: doc/BRIEF.md
# Limit Comparator with Masked Interrupt

This block watches a set of 8-bit measurements from a hardware monitor: six supply-voltage channels, one temperature channel and two fan-tachometer counts. Whenever a new measurement arrives on the write-strobe input, the value is stored and then checked against the limits programmed for its channel in the following cycle. A single comparator is shared by all channels. Voltages and temperature have a high and a low limit. A fan count has only a high limit, because a slow fan produces a large count.

A failed check sets a sticky bit in the interrupt status registers. The bit stays set until software reads its status register. At that read it is cleared, unless the most recent check of that channel still failed. Each channel has its own mask bit. The interrupt pin is active low and modelled as an open-drain enable. It stays released until software sets the enable bit in the configuration register.

Software reaches all registers through a byte-wide port with an address pointer. The pointer is loaded by one strobe and advances after every data read or write, so consecutive registers can be accessed in a burst.

Top module: `hwmon_limit_irq`

## Requirements
- R1: After reset, `irq_n` is 1, every value, status, mask and configuration register reads 0, every high limit reads 0xFF, every low limit reads 0x00, and the pointer is 0.
- R2: Channels 0 to 5 (voltages) and channel 6 (temperature) fail when the value is strictly above the high limit or strictly below the low limit (unsigned). A value equal to either limit passes.
- R3: Channels 7 and 8 (fans) fail only when the count is strictly above the high limit. Low-limit addresses 0x27 and 0x28 ignore writes and read 0.
- R4: A measurement sampled at clock edge N can be read back at address 0x00+channel after edge N. It is compared during the next cycle, and its status bit and `irq_n` reflect the result after edge N+1.
- R5: A status bit stays set after later checks of its channel pass, until its status register is read.
- R6: A read strobe at 0x30 (channels 0 to 7 in bits 0 to 7) or 0x31 (channel 8 in bit 0) returns the current bits. On that edge it clears every bit whose latest check passed and keeps every bit whose latest check failed.
- R7: When a check and a read of the same status register fall on the same edge, a failing check leaves its bit set and a passing check clears it.
- R8: `irq_n` is 0 exactly when bit 1 of the configuration register (0x3F) is 1 and some status bit is set whose mask bit is 0. Mask bits sit at 0x32 (channels 0 to 7) and 0x33 bit 0 (channel 8). A mask bit of 1 suppresses its channel.
- R9: Register map: values at 0x00 to 0x08, high limits at 0x10 to 0x18, low limits at 0x20 to 0x26, status at 0x30 to 0x31, mask at 0x32 to 0x33, configuration at 0x3F. Any other address reads 0.
- R10: `bus_ptr_we` loads the pointer from `bus_wdata[5:0]`. Each `bus_rd` or `bus_wr` strobe then advances it by one, wrapping from 0x3F to 0x00. `bus_rdata` always shows the register at the pointer.
- R11: Port writes to value or status addresses have no effect, and a measurement strobe with `meas_sel` of 9 or more changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| meas_we | input | 1 | New measurement strobe |
| meas_sel | input | 4 | Channel of the measurement |
| meas_val | input | 8 | Measured value |
| bus_ptr_we | input | 1 | Load address pointer from `bus_wdata` |
| bus_wr | input | 1 | Write `bus_wdata` at pointer, then advance |
| bus_rd | input | 1 | Consume `bus_rdata`, clear status if addressed, then advance |
| bus_wdata | input | 8 | Pointer or write data |
| bus_rdata | output | 8 | Register at pointer |
| irq_n | output | 1 | Active-low interrupt (0 = pull pin low) |

## Verification
The comparison of a fresh measurement and a clear-on-read of the status register holding its bit can land on the same clock edge. The bench provokes this by pre-loading the pointer at 0x30 and raising `bus_rd` in the cycle right after a measurement strobe. It does this once with a failing value and once with a passing value. The bench model applies the clear first and the new result second, and the following status read and `irq_n` are judged against that model.

// File: rtl/hwmon_lim_pkg.sv
// Shared address map and constants for the limit comparator.
// Assumes at most 16 channels, so status and mask each fit in two bytes.
package hwmon_lim_pkg;
    localparam int ADDR_W = 6;
    typedef logic [ADDR_W-1:0] reg_addr_t;

    localparam reg_addr_t ADR_VALUE = 6'h00;
    localparam reg_addr_t ADR_HIGH  = 6'h10;
    localparam reg_addr_t ADR_LOW   = 6'h20;
    localparam reg_addr_t ADR_STAT  = 6'h30;
    localparam reg_addr_t ADR_MASK  = 6'h32;
    localparam reg_addr_t ADR_CFG   = 6'h3F;

    localparam int CFG_IRQ_EN = 1;
endpackage

// File: rtl/hwmon_lim_regs.sv
// Register file: stores measurements, limits, masks and the configuration
// byte, owns the address pointer, and serves the read mux.
// Assumes DW-wide status/mask banks, NCH <= 2*DW, and strobes that are one
// cycle wide. A pointer load wins over a data strobe in the same cycle.
module hwmon_lim_regs
    import hwmon_lim_pkg::*;
#(
    parameter int NCH  = 9,
    parameter int NLIM = 7,
    parameter int DW   = 8,
    parameter int SW   = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    meas_we,
    input  logic [SW-1:0]           meas_sel,
    input  logic [DW-1:0]           meas_val,
    input  logic                    ptr_we,
    input  logic                    wr,
    input  logic                    rd,
    input  logic [DW-1:0]           wdata,
    output logic [DW-1:0]           rdata,
    input  logic [NCH-1:0]          status,
    output logic [NCH-1:0][DW-1:0]  val_q,
    output logic [NCH-1:0][DW-1:0]  hi_q,
    output logic [NCH-1:0][DW-1:0]  lo_q,
    output logic [NCH-1:0]          mask_q,
    output logic                    irq_en,
    output logic [NCH-1:0]          rd_clr
);
    localparam int NB = (NCH + DW - 1) / DW;

    reg_addr_t       ptr_q;
    logic [DW-1:0]   cfg_q;
    logic            wr_go;
    logic            rd_go;
    logic [NB*DW-1:0] stat_pad;
    logic [NB*DW-1:0] mask_pad;

    assign wr_go    = wr && !ptr_we;
    assign rd_go    = rd && !ptr_we;
    assign irq_en   = cfg_q[CFG_IRQ_EN];
    assign stat_pad = (NB*DW)'(status);
    assign mask_pad = (NB*DW)'(mask_q);

    // Capture each accepted measurement into its channel's value register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q <= '0;
        end else begin
            for (int ch = 0; ch < NCH; ch++) begin
                if (meas_we && int'(meas_sel) == ch) val_q[ch] <= meas_val;
            end
        end
    end

    // High limits, written through the port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= '1;
        end else begin
            for (int ch = 0; ch < NCH; ch++) begin
                if (wr_go && ptr_q == ADR_HIGH + ADDR_W'(ch)) hi_q[ch] <= wdata;
            end
        end
    end

    // Low limits; fan entries are never written and stay at zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
        end else begin
            for (int ch = 0; ch < NLIM; ch++) begin
                if (wr_go && ptr_q == ADR_LOW + ADDR_W'(ch)) lo_q[ch] <= wdata;
            end
        end
    end

    // Per-channel mask bits packed DW to a byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else begin
            for (int ch = 0; ch < NCH; ch++) begin
                if (wr_go && ptr_q == ADR_MASK + ADDR_W'(ch / DW))
                    mask_q[ch] <= wdata[ch % DW];
            end
        end
    end

    // Configuration byte holding the interrupt enable
    always_ff @(posedge clk) begin
        if (!rst_n)                          cfg_q <= '0;
        else if (wr_go && ptr_q == ADR_CFG)  cfg_q <= wdata;
    end

    // Address pointer: load, or step after each data access
    always_ff @(posedge clk) begin
        if (!rst_n)              ptr_q <= '0;
        else if (ptr_we)         ptr_q <= wdata[ADDR_W-1:0];
        else if (wr_go || rd_go) ptr_q <= ptr_q + ADDR_W'(1);
    end

    // Clear requests for the status bank under a read strobe
    always_comb begin
        for (int ch = 0; ch < NCH; ch++)
            rd_clr[ch] = rd_go && (ptr_q == ADR_STAT + ADDR_W'(ch / DW));
    end

    // Read mux for the register at the pointer
    always_comb begin
        rdata = '0;
        for (int ch = 0; ch < NCH; ch++) begin
            if (ptr_q == ADR_VALUE + ADDR_W'(ch)) rdata = val_q[ch];
            if (ptr_q == ADR_HIGH + ADDR_W'(ch))  rdata = hi_q[ch];
            if (ch < NLIM && ptr_q == ADR_LOW + ADDR_W'(ch)) rdata = lo_q[ch];
        end
        for (int b = 0; b < NB; b++) begin
            if (ptr_q == ADR_STAT + ADDR_W'(b)) rdata = stat_pad[b*DW +: DW];
            if (ptr_q == ADR_MASK + ADDR_W'(b)) rdata = mask_pad[b*DW +: DW];
        end
        if (ptr_q == ADR_CFG) rdata = cfg_q;
    end

    // R10
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ptr_we && (wr || rd)) |=> ptr_q == $past(ptr_q) + ADDR_W'(1));

    // R11
    value_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !meas_we |=> $stable(val_q));
endmodule

// File: rtl/hwmon_lim_cmp.sv
// Shared compare stage: registers the channel of the latest accepted
// measurement and checks the stored value against that channel's limits
// one cycle later. Channels at or above NLIM have no low limit.
// Assumes at most one measurement strobe per cycle.
module hwmon_lim_cmp #(
    parameter int NCH  = 9,
    parameter int NLIM = 7,
    parameter int DW   = 8,
    parameter int SW   = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    meas_we,
    input  logic [SW-1:0]           meas_sel,
    input  logic [NCH-1:0][DW-1:0]  val_q,
    input  logic [NCH-1:0][DW-1:0]  hi_q,
    input  logic [NCH-1:0][DW-1:0]  lo_q,
    output logic [NCH-1:0]          cmp_hit,
    output logic                    cmp_bad
);
    logic           pend_q;
    logic [SW-1:0]  idx_q;
    logic [DW-1:0]  cur_v;
    logic [DW-1:0]  cur_hi;
    logic [DW-1:0]  cur_lo;
    logic           has_low;

    // Queue the next compare for an in-range channel
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            idx_q  <= '0;
        end else begin
            pend_q <= meas_we && (int'(meas_sel) < NCH);
            idx_q  <= meas_sel;
        end
    end

    // Fetch the operands of the queued channel and judge them
    always_comb begin
        cur_v   = val_q[idx_q];
        cur_hi  = hi_q[idx_q];
        cur_lo  = lo_q[idx_q];
        has_low = int'(idx_q) < NLIM;
        cmp_bad = pend_q && ((cur_v > cur_hi) || (has_low && cur_v < cur_lo));
        for (int ch = 0; ch < NCH; ch++)
            cmp_hit[ch] = pend_q && (int'(idx_q) == ch);
    end

    // R3
    fan_low_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && int'(idx_q) >= NLIM && cur_v <= cur_hi) |-> !cmp_bad);

    // R4
    one_compare_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmp_hit));
endmodule

// File: rtl/hwmon_lim_stat.sv
// Sticky status bits with clear-on-read, and the gated interrupt.
// A bit is set by a failing compare; a read clears it to the latest
// compare result of its channel, and a same-edge compare takes precedence.
module hwmon_lim_stat #(
    parameter int NCH = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCH-1:0]  cmp_hit,
    input  logic            cmp_bad,
    input  logic [NCH-1:0]  rd_clr,
    input  logic [NCH-1:0]  mask_q,
    input  logic            irq_en,
    output logic [NCH-1:0]  status,
    output logic            irq_n
);
    logic [NCH-1:0] stat_q;
    logic [NCH-1:0] live_q;
    logic [NCH-1:0] live_now;

    // Latest compare result per channel, including this cycle's compare
    always_comb begin
        for (int ch = 0; ch < NCH; ch++)
            live_now[ch] = cmp_hit[ch] ? cmp_bad : live_q[ch];
    end

    // Hold the latest result and update the sticky bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q <= '0;
            stat_q <= '0;
        end else begin
            live_q <= live_now;
            for (int ch = 0; ch < NCH; ch++)
                stat_q[ch] <= (cmp_hit[ch] && cmp_bad) |
                              (rd_clr[ch] ? live_now[ch] : stat_q[ch]);
        end
    end

    assign status = stat_q;
    assign irq_n  = !(irq_en && |(stat_q & ~mask_q));

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        // R4
        set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cmp_hit[g] && cmp_bad) |=> stat_q[g]);
        // R5
        sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_q[g] && !rd_clr[g]) |=> stat_q[g]);
        // R6
        clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_clr[g] && !cmp_hit[g] && !live_q[g]) |=> !stat_q[g]);
    end
endmodule

// File: rtl/hwmon_limit_irq.sv
// Top of the limit comparator: six voltage channels, one temperature
// channel and two fan counts by default. Measurements enter through a
// write strobe; software uses a pointer-addressed byte port.
module hwmon_limit_irq #(
    parameter int N_VOLT = 6,
    parameter int N_TEMP = 1,
    parameter int N_FAN  = 2,
    parameter int DW     = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        meas_we,
    input  logic [3:0]  meas_sel,
    input  logic [7:0]  meas_val,
    input  logic        bus_ptr_we,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    output logic        irq_n
);
    localparam int NCH  = N_VOLT + N_TEMP + N_FAN;
    localparam int NLIM = N_VOLT + N_TEMP;
    localparam int SW   = 4;

    logic [NCH-1:0][DW-1:0] val_q;
    logic [NCH-1:0][DW-1:0] hi_q;
    logic [NCH-1:0][DW-1:0] lo_q;
    logic [NCH-1:0]         mask_q;
    logic [NCH-1:0]         rd_clr;
    logic [NCH-1:0]         cmp_hit;
    logic [NCH-1:0]         status;
    logic                   cmp_bad;
    logic                   irq_en;

    hwmon_lim_regs #(.NCH(NCH), .NLIM(NLIM), .DW(DW), .SW(SW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .meas_we  (meas_we),
        .meas_sel (meas_sel),
        .meas_val (meas_val),
        .ptr_we   (bus_ptr_we),
        .wr       (bus_wr),
        .rd       (bus_rd),
        .wdata    (bus_wdata),
        .rdata    (bus_rdata),
        .status   (status),
        .val_q    (val_q),
        .hi_q     (hi_q),
        .lo_q     (lo_q),
        .mask_q   (mask_q),
        .irq_en   (irq_en),
        .rd_clr   (rd_clr)
    );

    hwmon_lim_cmp #(.NCH(NCH), .NLIM(NLIM), .DW(DW), .SW(SW)) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .meas_we  (meas_we),
        .meas_sel (meas_sel),
        .val_q    (val_q),
        .hi_q     (hi_q),
        .lo_q     (lo_q),
        .cmp_hit  (cmp_hit),
        .cmp_bad  (cmp_bad)
    );

    hwmon_lim_stat #(.NCH(NCH)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmp_hit  (cmp_hit),
        .cmp_bad  (cmp_bad),
        .rd_clr   (rd_clr),
        .mask_q   (mask_q),
        .irq_en   (irq_en),
        .status   (status),
        .irq_n    (irq_n)
    );

    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> irq_n);
endmodule

// File: tb/hwmon_limit_irq_test.sv
`timescale 1ns/1ps
module hwmon_limit_irq_test;
    localparam int NCH  = 9;
    localparam int NLIM = 7;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       meas_we;
    logic [3:0] meas_sel;
    logic [7:0] meas_val;
    logic       bus_ptr_we;
    logic       bus_wr;
    logic       bus_rd;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic       irq_n;

    int checks = 0;
    int errors = 0;

    logic [7:0]     m_val [NCH];
    logic [7:0]     m_hi  [NCH];
    logic [7:0]     m_lo  [NCH];
    logic [7:0]     m_cfg;
    logic [NCH-1:0] m_mask;
    logic [NCH-1:0] m_stat;
    logic [NCH-1:0] m_live;
    logic [5:0]     m_ptr;

    always #2.5 clk = ~clk;

    hwmon_limit_irq uut (
        .clk(clk), .rst_n(rst_n), .meas_we(meas_we), .meas_sel(meas_sel),
        .meas_val(meas_val), .bus_ptr_we(bus_ptr_we), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_n(irq_n)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic oor(input int ch, input logic [7:0] v);
        return (v > m_hi[ch]) || (ch < NLIM && v < m_lo[ch]);
    endfunction

    function automatic logic [7:0] exp_reg(input logic [5:0] a);
        logic [15:0] sp;
        logic [15:0] mp;
        sp = 16'(m_stat);
        mp = 16'(m_mask);
        for (int ch = 0; ch < NCH; ch++) begin
            if (a == 6'(ch)) return m_val[ch];
            if (a == 6'h10 + 6'(ch)) return m_hi[ch];
            if (ch < NLIM && a == 6'h20 + 6'(ch)) return m_lo[ch];
        end
        case (a)
            6'h30:   return sp[7:0];
            6'h31:   return sp[15:8];
            6'h32:   return mp[7:0];
            6'h33:   return mp[15:8];
            6'h3F:   return m_cfg;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic exp_irq_n();
        return !(m_cfg[1] && |(m_stat & ~m_mask));
    endfunction

    task automatic model_write(input logic [5:0] a, input logic [7:0] d);
        for (int ch = 0; ch < NCH; ch++) begin
            if (a == 6'h10 + 6'(ch)) m_hi[ch] = d;
            if (ch < NLIM && a == 6'h20 + 6'(ch)) m_lo[ch] = d;
        end
        if (a == 6'h32) for (int ch = 0; ch < 8; ch++) m_mask[ch] = d[ch];
        if (a == 6'h33) m_mask[8] = d[0];
        if (a == 6'h3F) m_cfg = d;
    endtask

    task automatic model_clear(input logic [5:0] a);
        if (a == 6'h30) for (int ch = 0; ch < 8; ch++) m_stat[ch] = m_live[ch];
        if (a == 6'h31) m_stat[8] = m_live[8];
    endtask

    task automatic model_meas(input logic [3:0] sel, input logic [7:0] v);
        logic b;
        if (int'(sel) < NCH) begin
            m_val[sel] = v;
            b = oor(int'(sel), v);
            m_live[sel] = b;
            if (b) m_stat[sel] = 1'b1;
        end
    endtask

    task automatic set_ptr(input logic [5:0] a);
        bus_ptr_we = 1'b1;
        bus_wdata  = {2'b00, a};
        @(negedge clk);
        bus_ptr_we = 1'b0;
        m_ptr = a;
    endtask

    task automatic wr_next(input logic [7:0] d);
        bus_wr    = 1'b1;
        bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        model_write(m_ptr, d);
        m_ptr = m_ptr + 6'd1;
    endtask

    task automatic rd_next(input string tag);
        check(tag, bus_rdata, exp_reg(m_ptr));
        bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        model_clear(m_ptr);
        m_ptr = m_ptr + 6'd1;
    endtask

    task automatic write_reg(input logic [5:0] a, input logic [7:0] d);
        set_ptr(a);
        wr_next(d);
    endtask

    task automatic read_reg(input logic [5:0] a, input string tag);
        set_ptr(a);
        rd_next(tag);
    endtask

    task automatic meas(input logic [3:0] sel, input logic [7:0] v);
        meas_we  = 1'b1;
        meas_sel = sel;
        meas_val = v;
        @(negedge clk);
        meas_we = 1'b0;
        @(negedge clk);
        model_meas(sel, v);
    endtask

    task automatic chk_irq(input string tag);
        check(tag, {7'b0, irq_n}, {7'b0, exp_irq_n()});
    endtask

    // Measurement whose compare edge coincides with a status read at 0x30
    task automatic meas_with_read(input logic [3:0] sel, input logic [7:0] v);
        set_ptr(6'h30);
        meas_we  = 1'b1;
        meas_sel = sel;
        meas_val = v;
        @(negedge clk);
        meas_we = 1'b0;
        check("R7 read data before compare", bus_rdata, exp_reg(6'h30));
        bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        m_val[sel]  = v;
        m_live[sel] = oor(int'(sel), v);
        model_clear(6'h30);
        if (m_live[sel]) m_stat[sel] = 1'b1;
        m_ptr = 6'h31;
        read_reg(6'h30, "R7 status after same-edge read");
        chk_irq("R7 irq");
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; meas_we = 1'b0; meas_sel = '0; meas_val = '0;
        bus_ptr_we = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
        for (int ch = 0; ch < NCH; ch++) begin
            m_val[ch] = 8'h00; m_hi[ch] = 8'hFF; m_lo[ch] = 8'h00;
        end
        m_cfg = '0; m_mask = '0; m_stat = '0; m_live = '0; m_ptr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state, R9 map and R10 burst wrap over the whole space
        chk_irq("R1 irq released");
        check("R1 pointer at value 0", bus_rdata, 8'h00);
        for (int i = 0; i < 64; i++) rd_next("R1 R9 reset burst read");
        check("R10 wrap to address 0", bus_rdata, exp_reg(6'h00));

        // R4 latency of value, status and interrupt
        write_reg(6'h11, 8'h10);
        write_reg(6'h3F, 8'h02);
        set_ptr(6'h01);
        meas_we = 1'b1; meas_sel = 4'd1; meas_val = 8'h50;
        @(negedge clk);
        meas_we = 1'b0;
        check("R4 value after strobe edge", bus_rdata, 8'h50);
        chk_irq("R4 irq not yet");
        @(negedge clk);
        model_meas(4'd1, 8'h50);
        check("R4 irq after compare edge", {7'b0, irq_n}, 8'h00);

        // R5 sticky, R8 mask and enable, R6 clear
        meas(4'd1, 8'h05);
        chk_irq("R5 irq held");
        write_reg(6'h32, 8'h02);
        chk_irq("R8 masked");
        write_reg(6'h32, 8'h00);
        chk_irq("R8 unmasked");
        write_reg(6'h3F, 8'h00);
        chk_irq("R8 disabled");
        write_reg(6'h3F, 8'h02);
        read_reg(6'h30, "R5 sticky bit read");
        read_reg(6'h30, "R6 cleared after read");
        chk_irq("R6 irq released");

        // R2 boundaries on a voltage channel
        write_reg(6'h10, 8'h80);
        write_reg(6'h20, 8'h40);
        meas(4'd0, 8'h80); read_reg(6'h30, "R2 equal high passes");
        meas(4'd0, 8'h40); read_reg(6'h30, "R2 equal low passes");
        meas(4'd0, 8'h81); read_reg(6'h30, "R2 above high fails");
        meas(4'd0, 8'h60); read_reg(6'h30, "R2 clear after pass");
        meas(4'd0, 8'h3F); read_reg(6'h30, "R2 below low fails");
        meas(4'd6, 8'hC0); write_reg(6'h16, 8'h90); meas(4'd6, 8'hC0);
        read_reg(6'h30, "R2 temperature above high");

        // R3 fan channels
        write_reg(6'h27, 8'h55);
        read_reg(6'h27, "R3 fan low address reads 0");
        write_reg(6'h18, 8'h30);
        meas(4'd8, 8'h00); read_reg(6'h31, "R3 fan low count passes");
        meas(4'd8, 8'h31); read_reg(6'h31, "R3 fan above limit fails");
        chk_irq("R3 irq from fan");
        meas(4'd8, 8'h10); read_reg(6'h31, "R3 fan bit read");
        read_reg(6'h31, "R3 fan bit cleared");

        // R7 same-edge compare and status read
        write_reg(6'h12, 8'h20);
        meas_with_read(4'd2, 8'h21);
        meas_with_read(4'd2, 8'h05);

        // R11 writes and strobes that must not land
        write_reg(6'h02, 8'hAA);
        read_reg(6'h02, "R11 value write ignored");
        meas(4'd3, 8'hF0); write_reg(6'h13, 8'h10); meas(4'd3, 8'hF0);
        write_reg(6'h30, 8'h00);
        read_reg(6'h30, "R11 status write ignored");
        meas(4'd12, 8'hFF);
        for (int ch = 0; ch < NCH; ch++) read_reg(6'(ch), "R11 invalid channel strobe");
        chk_irq("R11 irq after invalid strobe");

        // Random mix
        for (int i = 0; i < 500; i++) begin
            int op;
            op = int'($urandom % 10);
            if (op < 4) begin
                meas(4'($urandom % 11), 8'($urandom));
            end else if (op == 4) begin
                write_reg(($urandom % 2) ? 6'h10 + 6'($urandom % 9) : 6'h20 + 6'($urandom % 9),
                          8'($urandom));
            end else if (op == 5) begin
                write_reg(6'h32 + 6'($urandom % 2), 8'($urandom % 4 == 0 ? $urandom : 0));
            end else if (op == 6) begin
                write_reg(6'h3F, 8'($urandom) | (($urandom % 4 != 0) ? 8'h02 : 8'h00));
            end else if (op < 9) begin
                set_ptr(6'h30);
                rd_next("R6 R5 random status read");
                rd_next("R10 random burst status");
            end else begin
                read_reg(6'($urandom), "R9 random register read");
            end
            chk_irq("R8 random irq");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule